// File: doc/BRIEF.md
# Serial Bus Word-Complete Handshake Controller

This block runs the service handshake between a byte-serial two-wire bus engine and the software that feeds or drains its data buffer. It keeps a ready flag that is active low: the flag reads 0 while a finished word waits for software and 1 once software has dealt with it. When the shift engine reports a finished word, the flag drops to 0. At the same moment the block raises a one-clock interrupt and starts pulling the clock line low, so the bus stalls. The same drop happens when, with address recognition on, the engine receives a slave address equal to the block's own address or the all-zero general-call address.

Software restores the flag to 1 by accessing the data buffer in the direction that matches the current transfer: a buffer write when transmitting, a buffer read when receiving. It may also write a 1 to the flag through the control port. Even after the flag returns to 1, the clock line stays low for a programmable number of system clocks, so the bus low time is met. A control write also selects the operating mode. A mode change is taken only while the bus is idle.

Top module: `word_handshake_ctrl`

## Requirements
- R1: After reset, `ready_n_flag` is 1, `irq` is 0, `scl_hold` is 0 and `mode` is 2'b00 (port mode).
- R2: With `mode` equal to 2'b10 (bus mode), a `word_done` strobe drops `ready_n_flag` to 0 one cycle later, and `irq` is 1 in that same cycle only. A `word_done` outside bus mode has no effect on the flag or `irq`.
- R3: In any cycle where `ready_n_flag` is 0, `scl_hold` is 1.
- R4: With `xmit` = 1, a `buf_wr` strobe sets `ready_n_flag` to 1 on the next cycle, and a `buf_rd` strobe leaves it unchanged.
- R5: With `xmit` = 0, a `buf_rd` strobe sets `ready_n_flag` to 1 on the next cycle, and a `buf_wr` strobe leaves it unchanged.
- R6: A `ctl_wr` with `ctl_wdata[2]` = 1 sets `ready_n_flag` to 1. A `ctl_wr` with `ctl_wdata[2]` = 0 leaves the flag unchanged.
- R7: In bus mode with `addr_recog` = 1, an `addr_stb` whose `rx_addr` equals `own_addr` or is all zeros clears `ready_n_flag` and pulses `irq`, just as R2 does. Any other address, or `addr_recog` = 0, has no effect.
- R8: When `ready_n_flag` rises, `scl_hold` stays 1 for exactly `low_time` cycles in which the flag is 1. With `low_time` = 0, `scl_hold` is 0 in the first cycle the flag reads 1.
- R9: A `ctl_wr` loads `mode` from `ctl_wdata[1:0]` when `bus_busy` = 0. The write is ignored and `mode` keeps its value when `bus_busy` = 1.
- R10: If a clearing event (R2, R7) and a setting event (R4, R5, R6) occur in the same cycle, the clear wins.
- R11: `irq` never pulses when `ready_n_flag` is already 0. A repeated clear gives no second interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_done | input | 1 | End-of-word strobe from the shift engine |
| xmit | input | 1 | 1 = transmitter, 0 = receiver |
| addr_recog | input | 1 | Address recognition enable |
| addr_stb | input | 1 | Received slave address valid strobe |
| rx_addr | input | ADDR_W | Received slave address |
| own_addr | input | ADDR_W | Own slave address |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_rd | input | 1 | Data buffer read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit 2: set flag; bits 1:0: mode |
| bus_busy | input | 1 | Bus is between START and STOP |
| low_time | input | CNT_W | Clock-low hold time in system clocks |
| ready_n_flag | output | 1 | Active-low pending flag |
| irq | output | 1 | One-cycle word-complete interrupt |
| scl_hold | output | 1 | Pull the clock line low |
| mode | output | 2 | Current operating mode |

## Verification
The bench targets the same-cycle collision of a clear and a set. A design that let the set win would release the bus with a word still unserviced. It also issues a buffer access in the wrong direction, which a careless design would take as service. A low time of zero catches a release counter that is off by one, because such a design would either hold the clock one extra cycle or drop the hold while the flag still reads 0. A mode write while the bus is busy, a non-matching address, and a second word-done while already pending each expose a design that changes mode, raises a false interrupt, or fires the interrupt twice.

// File: rtl/word_hs_pkg.sv
package word_hs_pkg;
  typedef enum logic [1:0] {
    MODE_PORT = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_BUS  = 2'b10,
    MODE_RSV3 = 2'b11
  } hs_mode_t;

  localparam int CTL_W       = 3;
  localparam int CTL_SET_BIT = 2;
endpackage

// File: rtl/whs_mode_reg.sv
module whs_mode_reg
  import word_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       bus_busy,
  input  logic [1:0] wr_mode,
  output logic [1:0] mode_q,
  output logic       bus_on
);
  hs_mode_t mode_r;

  // A mode change is taken only while the bus is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mode_r <= MODE_PORT;
    else if (ctl_wr && !bus_busy) mode_r <= hs_mode_t'(wr_mode);
  end

  assign mode_q = mode_r;
  assign bus_on = (mode_r == MODE_BUS);
endmodule

// File: rtl/whs_pend_ctrl.sv
module whs_pend_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_evt,
  input  logic set_evt,
  output logic pend_q,
  output logic irq_q,
  output logic rise_evt
);
  // Clear has priority over set; irq marks the 1->0 edge only
  function automatic logic next_pend(input logic cur, input logic clr, input logic set);
    if (clr)      return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction

  assign rise_evt = set_evt && !clear_evt && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= next_pend(pend_q, clear_evt, set_evt);
      irq_q  <= clear_evt && pend_q;
    end
  end
endmodule

// File: rtl/whs_release_timer.sv
module whs_release_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_evt,
  input  logic             rise_evt,
  input  logic [CNT_W-1:0] low_time,
  output logic             running
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_cnt(
    input logic [CNT_W-1:0] cur, input logic clr, input logic load,
    input logic [CNT_W-1:0] ld_val);
    if (clr)            return '0;
    else if (load)      return ld_val;
    else if (cur != '0) return cur - 1'b1;
    else                return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, clear_evt, rise_evt, low_time);
  end

  assign running = (cnt_q != '0);
endmodule

// File: rtl/word_handshake_ctrl.sv
module word_handshake_ctrl
  import word_hs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic              xmit,
  input  logic              addr_recog,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              buf_wr,
  input  logic              buf_rd,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              bus_busy,
  input  logic [CNT_W-1:0]  low_time,
  output logic              ready_n_flag,
  output logic              irq,
  output logic              scl_hold,
  output logic [1:0]        mode
);
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] own);
    return (a == own) || (a == '0);
  endfunction

  logic bus_on, addr_evt, clear_evt, set_evt, rise_evt, timer_run;

  assign addr_evt  = addr_stb && addr_recog && addr_hit(rx_addr, own_addr);
  assign clear_evt = bus_on && (word_done || addr_evt);
  assign set_evt   = (buf_wr && xmit) || (buf_rd && !xmit) ||
                     (ctl_wr && ctl_wdata[CTL_SET_BIT]);

  whs_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .bus_busy(bus_busy),
    .wr_mode(ctl_wdata[1:0]), .mode_q(mode), .bus_on(bus_on)
  );

  whs_pend_ctrl u_pend (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .set_evt(set_evt),
    .pend_q(ready_n_flag), .irq_q(irq), .rise_evt(rise_evt)
  );

  whs_release_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .rise_evt(rise_evt),
    .low_time(low_time), .running(timer_run)
  );

  assign scl_hold = !ready_n_flag || timer_run;
endmodule

// File: rtl/whs_checker.sv
module whs_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready_n_flag,
  input logic             irq,
  input logic             scl_hold,
  input logic [1:0]       mode,
  input logic             ctl_wr,
  input logic             bus_busy,
  input logic             clear_evt,
  input logic             set_evt,
  input logic             rise_evt,
  input logic             addr_evt,
  input logic [CNT_W-1:0] low_time
);
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ready_n_flag);                                            // R2
  AST_FALL_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n_flag) |-> irq);                                      // R2
  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n_flag |-> scl_hold);                                       // R3
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !clear_evt) |=> ready_n_flag);                         // R6
  AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && clear_evt) |=> !ready_n_flag);                        // R7
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && low_time == '0) |=> !scl_hold);                       // R8
  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && low_time != '0) |=> scl_hold);                        // R8
  AST_MODE_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_busy) |=> $stable(mode));                           // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && set_evt) |=> !ready_n_flag);                         // R10
  AST_NO_DOUBLE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !ready_n_flag) |=> !irq);                            // R11
endmodule

bind word_handshake_ctrl whs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_n_flag(ready_n_flag), .irq(irq),
  .scl_hold(scl_hold), .mode(mode), .ctl_wr(ctl_wr), .bus_busy(bus_busy),
  .clear_evt(clear_evt), .set_evt(set_evt), .rise_evt(rise_evt),
  .addr_evt(addr_evt), .low_time(low_time)
);

// File: tb/word_handshake_ctrl_tb.sv
module word_handshake_ctrl_tb;
  localparam int AW = 7;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic word_done = 0, xmit = 0, addr_recog = 0, addr_stb = 0;
  logic [AW-1:0] rx_addr = '0, own_addr = 7'h2a;
  logic buf_wr = 0, buf_rd = 0, ctl_wr = 0, bus_busy = 0;
  logic [2:0] ctl_wdata = '0;
  logic [CW-1:0] low_time = '0;
  logic ready_n_flag, irq, scl_hold;
  logic [1:0] mode;

  int checks = 0, failures = 0;
  bit finished = 0;

  // expected-state model
  logic m_pend = 1, m_irq = 0;
  logic [1:0] m_mode = 2'b00;
  int m_cnt = 0;

  always #10 clk = ~clk; // 50 MHz

  word_handshake_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .xmit(xmit),
    .addr_recog(addr_recog), .addr_stb(addr_stb), .rx_addr(rx_addr),
    .own_addr(own_addr), .buf_wr(buf_wr), .buf_rd(buf_rd), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .bus_busy(bus_busy), .low_time(low_time),
    .ready_n_flag(ready_n_flag), .irq(irq), .scl_hold(scl_hold), .mode(mode)
  );

  function automatic logic exp_clear();
    logic hit;
    hit = addr_stb && addr_recog && (rx_addr == own_addr || rx_addr == '0);
    return (m_mode == 2'b10) && (word_done || hit);
  endfunction

  function automatic logic exp_set();
    return (xmit ? buf_wr : buf_rd) || (ctl_wr && ctl_wdata[2]);
  endfunction

  function automatic logic exp_hold();
    return !m_pend || (m_cnt != 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " flag"}, ready_n_flag, m_pend);
    chk({tag, " irq"}, irq, m_irq);
    chk({tag, " hold"}, scl_hold, exp_hold());
    chk({tag, " mode"}, mode, m_mode);
  endtask

  // one clock: model updates from inputs held across the edge
  task automatic tick();
    logic c, s;
    @(posedge clk);
    c = exp_clear();
    s = exp_set();
    m_irq = c && m_pend;
    if (c) begin
      m_pend = 0; m_cnt = 0;
    end else if (s && !m_pend) begin
      m_pend = 1; m_cnt = low_time;
    end else if (m_cnt > 0) m_cnt--;
    if (ctl_wr && !bus_busy) m_mode = ctl_wdata[1:0];
    @(negedge clk);
    word_done = 0; addr_stb = 0; buf_wr = 0; buf_rd = 0; ctl_wr = 0;
  endtask

  task automatic ctl(input logic setb, input logic [1:0] md);
    ctl_wr = 1; ctl_wdata = {setb, md}; tick();
  endtask

  initial begin
    int n;
    n = 0;
    while (!finished && n < 150000) begin @(posedge clk); n++; end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (2) @(negedge clk);
    chk("R1 reset flag", ready_n_flag, 1);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset hold", scl_hold, 0);
    chk("R1 reset mode", mode, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: word_done outside bus mode
    word_done = 1; tick();
    chk("R2 no clear in port mode", ready_n_flag, 1);
    chk("R2 no irq in port mode", irq, 0);

    // R9: busy blocks mode write, idle accepts it
    bus_busy = 1; ctl(0, 2'b10);
    chk("R9 busy write ignored", mode, 2'b00);
    bus_busy = 0; ctl(0, 2'b10);
    chk("R9 idle write taken", mode, 2'b10);

    // R2/R3: word done in bus mode
    word_done = 1; tick();
    chk("R2 flag cleared", ready_n_flag, 0);
    chk("R2 irq pulse", irq, 1);
    chk("R3 hold while pending", scl_hold, 1);
    tick();
    chk("R2 irq one cycle", irq, 0);
    // R11: second clear while pending
    word_done = 1; tick();
    chk("R11 no second irq", irq, 0);

    // R4 + R8: transmitter, low_time 3
    xmit = 1; low_time = 8'd3;
    buf_rd = 1; tick();
    chk("R4 read ignored in tx", ready_n_flag, 0);
    buf_wr = 1; tick();
    chk("R4 write sets flag", ready_n_flag, 1);
    chk("R8 hold cycle 1", scl_hold, 1);
    tick(); chk("R8 hold cycle 2", scl_hold, 1);
    tick(); chk("R8 hold cycle 3", scl_hold, 1);
    tick(); chk("R8 released after low_time", scl_hold, 0);

    // R5 + R8 zero delay: receiver
    xmit = 0; low_time = 8'd0;
    word_done = 1; tick();
    buf_wr = 1; tick();
    chk("R5 write ignored in rx", ready_n_flag, 0);
    buf_rd = 1; tick();
    chk("R5 read sets flag", ready_n_flag, 1);
    chk("R8 zero delay release", scl_hold, 0);

    // R6: control set bit
    word_done = 1; tick();
    ctl(0, 2'b10);
    chk("R6 write of 0 no effect", ready_n_flag, 0);
    ctl(1, 2'b10);
    chk("R6 write of 1 sets", ready_n_flag, 1);

    // R7: address recognition
    addr_recog = 1;
    addr_stb = 1; rx_addr = 7'h15; tick();
    chk("R7 mismatch ignored", ready_n_flag, 1);
    chk("R7 mismatch no irq", irq, 0);
    addr_stb = 1; rx_addr = own_addr; tick();
    chk("R7 own address clears", ready_n_flag, 0);
    chk("R7 own address irq", irq, 1);
    ctl(1, 2'b10);
    addr_stb = 1; rx_addr = '0; tick();
    chk("R7 general call clears", ready_n_flag, 0);
    ctl(1, 2'b10);
    addr_recog = 0; addr_stb = 1; rx_addr = own_addr; tick();
    chk("R7 recognition off ignored", ready_n_flag, 1);

    // R10: clear and set together
    xmit = 1; word_done = 1; buf_wr = 1; tick();
    chk("R10 clear wins", ready_n_flag, 0);
    chk("R10 irq on collision", irq, 1);
    cmp_all("R10 model");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      word_done  = ($urandom % 6) == 0;
      xmit       = ($urandom % 2) == 0;
      addr_recog = ($urandom % 2) == 0;
      addr_stb   = ($urandom % 8) == 0;
      case ($urandom % 4)
        0: rx_addr = own_addr;
        1: rx_addr = '0;
        default: rx_addr = AW'($urandom);
      endcase
      buf_wr   = ($urandom % 5) == 0;
      buf_rd   = ($urandom % 5) == 0;
      ctl_wr   = ($urandom % 12) == 0;
      ctl_wdata = (($urandom % 4) == 0) ? 3'($urandom) : {1'($urandom), 2'b10};
      bus_busy = ($urandom % 3) != 0;
      low_time = CW'($urandom % 6);
      tick();
      cmp_all("R2-model random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule